// File: doc/BRIEF.md
# Delayed Fixed-Length Stream Packet Source

This block is a stream manager that emits exactly one packet of fixed length after each reset. When reset is released, it spends a programmable number of clock cycles in a counting phase. It then presents a run of words whose payload counts upward from one. The final word carries the end-of-packet flag. The block follows the valid/ready handshake of AXI-Stream: a word moves only on a clock edge where both valid and ready are high. While the downstream side applies backpressure, the word being offered stays frozen.

After the final word is accepted, valid falls and a completion flag rises. The block then stays idle until the next reset. A reset in the middle of a packet discards the remaining words. The next packet starts over from the first word, after the full start delay. The byte strobe marks every byte as meaningful.

Top module: `pkt_stream_source`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active low), after that edge `m_tvalid`, `m_tlast` and `pkt_done` are all 0.
- R2: `m_tvalid` is first seen high after exactly `START_CYCLES` rising edges with `rst_n` high following reset, and is low before then.
- R3: The k-th word offered in a packet (k counted from 1) carries the value k on `m_tdata`.
- R4: Whenever `m_tvalid` is high, `m_tstrb` is all ones (4'hF for the 32-bit default).
- R5: A packet consists of exactly `WORDS` transfers. `m_tlast` is 1 only while word number `WORDS` is offered.
- R6: If `m_tvalid` is high and `m_tready` is low at a rising edge, then after that edge `m_tvalid` is still high and `m_tdata` and `m_tlast` are unchanged.
- R7: Once `m_tvalid` rises, it stays high with no gap until the word with `m_tlast` set has been accepted.
- R8: After the final word is accepted, `m_tvalid` is low and `pkt_done` is 1 from the next cycle on, whatever `m_tready` does, until reset.
- R9: A reset taken in the middle of a packet drops the remaining words. After release, the full start delay applies again and the payload restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| m_tvalid | output | 1 | A word is offered this cycle |
| m_tdata | output | DATA_W | Payload word |
| m_tstrb | output | DATA_W/8 | Byte strobe, all ones |
| m_tlast | output | 1 | Marks the final word of the packet |
| m_tready | input | 1 | Downstream can take a word at this edge |
| pkt_done | output | 1 | The whole packet has been delivered |

## Verification
Every output comes straight from registers, so each result shows up in the cycle after the edge that caused it. The bench drives `m_tready` on the falling edge and samples outputs on the falling edge, half a period after the edge they depend on.

The start delay is measured by counting rising edges from reset release until valid is first seen. The expected count is `START_CYCLES`. A stall at one edge is checked against the values captured at the previous falling edge.

Completion is checked one cycle after the final accepting edge. The bench keeps checking it across several later cycles with ready held high.

// File: rtl/pkt_src_pkg.sv
package pkt_src_pkg;

    // Phases of the packet source
    typedef enum logic [1:0] {
        PS_WAIT = 2'd0,   // counting the start delay
        PS_SEND = 2'd1,   // offering words
        PS_DONE = 2'd2    // packet delivered, idle until reset
    } phase_e;

    localparam int DEF_DATA_W       = 32;
    localparam int DEF_WORDS        = 8;
    localparam int DEF_START_CYCLES = 32;

    // Width of a counter that must hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/start_delay.sv
module start_delay #(
    parameter int START_CYCLES = pkt_src_pkg::DEF_START_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = pkt_src_pkg::cnt_width(START_CYCLES);
    localparam logic [CW-1:0] LAST_CNT = CW'(START_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i && !expire_o) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: the counter never runs past the programmed delay
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R2: expiry is a single pulse, the phase logic stops the count
    a_r2_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

endmodule

// File: rtl/word_seq.sv
module word_seq #(
    parameter int DATA_W = pkt_src_pkg::DEF_DATA_W,
    parameter int WORDS  = pkt_src_pkg::DEF_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    output logic [DATA_W-1:0] data_o,
    output logic              final_o
);
    localparam int IW = pkt_src_pkg::cnt_width(WORDS - 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

    logic [IW-1:0] idx_q;

    // Payload is the one-based word number
    assign data_o  = DATA_W'(idx_q) + DATA_W'(1);
    assign final_o = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance_i) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    // R5: the index is never advanced past the final word
    a_r5_no_advance_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |-> !final_o);

endmodule

// File: rtl/pkt_stream_source.sv
module pkt_stream_source #(
    parameter int DATA_W       = pkt_src_pkg::DEF_DATA_W,
    parameter int WORDS        = pkt_src_pkg::DEF_WORDS,
    parameter int START_CYCLES = pkt_src_pkg::DEF_START_CYCLES
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                m_tvalid,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tstrb,
    output logic                m_tlast,
    input  logic                m_tready,
    output logic                pkt_done
);
    import pkt_src_pkg::*;

    localparam int STRB_W = DATA_W / 8;

    phase_e             phase_q, phase_d;
    logic               expire;
    logic               accept;
    logic               advance;
    logic               is_final;
    logic [DATA_W-1:0]  word;

    start_delay #(.START_CYCLES(START_CYCLES)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (phase_q == PS_WAIT),
        .expire_o (expire)
    );

    word_seq #(.DATA_W(DATA_W), .WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .data_o    (word),
        .final_o   (is_final)
    );

    assign m_tvalid = (phase_q == PS_SEND);
    assign accept   = m_tvalid && m_tready;
    assign advance  = accept && !is_final;
    assign m_tdata  = word;
    assign m_tlast  = m_tvalid && is_final;
    assign m_tstrb  = {STRB_W{1'b1}};
    assign pkt_done = (phase_q == PS_DONE);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PS_WAIT: if (expire)             phase_d = PS_SEND;
            PS_SEND: if (accept && is_final) phase_d = PS_DONE;
            PS_DONE: phase_d = PS_DONE;
            default: phase_d = PS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PS_WAIT;
        else        phase_q <= phase_d;
    end

    // R1: reset clears the stream outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!m_tvalid && !m_tlast && !pkt_done));

    // R6: a stalled word is frozen
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R7: no bubbles before the final word is taken
    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !(m_tready && m_tlast)) |=> m_tvalid);

    // R5: last flag only on the final word value
    a_r5_last_word: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> (m_tvalid && m_tdata == DATA_W'(WORDS)));

    // R8: accepting the final word ends the packet
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> (pkt_done && !m_tvalid));

    // R8: completion never coexists with a valid word
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !m_tvalid);

endmodule

// File: tb/pkt_stream_source_test.sv
module pkt_stream_source_test;
    localparam int DW = 32;
    localparam int NW = 8;
    localparam int SC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_tready = 1'b0;
    logic          m_tvalid;
    logic [DW-1:0] m_tdata;
    logic [DW/8-1:0] m_tstrb;
    logic          m_tlast;
    logic          pkt_done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    pkt_stream_source #(.DATA_W(DW), .WORDS(NW), .START_CYCLES(SC)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_tvalid (m_tvalid),
        .m_tdata  (m_tdata),
        .m_tstrb  (m_tstrb),
        .m_tlast  (m_tlast),
        .m_tready (m_tready),
        .pkt_done (pkt_done)
    );

    // Ready pattern (bit per cycle, cycled) and a flag to hold ready low for 3 cycles on the final word
    localparam logic [16:0] VECS [5] = '{
        {16'hFFFF, 1'b0},
        {16'h5555, 1'b0},
        {16'h0F0F, 1'b1},
        {16'h1111, 1'b0},
        {16'hFFFF, 1'b1}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        m_tready = 1'b0;
        tick();
        tick();
        chk({req, " valid in reset"}, m_tvalid, 0);
        chk({req, " last in reset"}, m_tlast, 0);
        chk({req, " done in reset"}, pkt_done, 0);
        rst_n = 1'b1;
    endtask

    task automatic measure_delay(input string req);
        int n = 0;
        while (!m_tvalid && n < SC + 10) begin
            tick();
            n++;
        end
        chk({req, " start delay edges"}, n, SC);
    endtask

    task automatic stream(input logic [15:0] pat, input bit hold_last,
                          input int abort_after, output int got);
        int          cyc = 0;
        int          words = 0;
        int          held = 0;
        logic        pv = 1'b0;
        logic        pr = 1'b0;
        logic [DW-1:0] pd = '0;
        logic        pl = 1'b0;
        logic        r;
        while (words < NW && cyc < 400) begin
            if (pv && !pr) begin
                chk("R6 valid held", m_tvalid, 1);
                chk("R6 data held", m_tdata, pd);
                chk("R6 last held", m_tlast, pl);
            end else if (pv) begin
                chk("R7 no gap", m_tvalid, 1);
            end
            if (m_tvalid) begin
                chk("R3 data", m_tdata, words + 1);
                chk("R4 strobe", m_tstrb, 4'hF);
                chk("R5 last flag", m_tlast, (words == NW - 1) ? 1 : 0);
            end
            if (abort_after >= 0 && words == abort_after) break;
            r = pat[cyc % 16];
            if (hold_last && words == NW - 1 && held < 3) begin
                r = 1'b0;
                held++;
            end
            m_tready = r;
            pv = m_tvalid;
            pr = r;
            pd = m_tdata;
            pl = m_tlast;
            if (m_tvalid && r) words++;
            tick();
            cyc++;
        end
        got = words;
    endtask

    task automatic check_tail;
        int extra = 0;
        chk("R8 valid low after final", m_tvalid, 0);
        chk("R8 done after final", pkt_done, 1);
        m_tready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (m_tvalid || !pkt_done) extra++;
        end
        chk("R8 stays idle", extra, 0);
        m_tready = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        int got;
        // Table-driven packets
        foreach (VECS[i]) begin
            apply_reset("R1");
            measure_delay("R2");
            stream(VECS[i][16:1], VECS[i][0], -1, got);
            chk("R5 word count", got, NW);
            check_tail();
        end

        // Random backpressure with a stall held over the final word
        apply_reset("R1");
        measure_delay("R2");
        stream(16'($urandom), 1'b1, -1, got);
        chk("R5 word count random", got, NW);
        check_tail();

        // Reset in the middle of a packet
        apply_reset("R1");
        measure_delay("R2");
        stream(16'hFFFF, 1'b0, 3, got);
        chk("R9 partial count", got, 3);
        apply_reset("R9");
        measure_delay("R9");
        chk("R9 restart word", m_tdata, 1);
        stream(16'hFFFF, 1'b0, -1, got);
        chk("R9 full packet after restart", got, NW);
        check_tail();

        summary();
        $finish;
    end

endmodule